// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the device side of a byte-wide mailbox through which a host processor reaches a 256-byte register space owned by an embedded controller. The host sees three locations on a small I/O bus: a data port, a status/command port (status when read, command when written) and an interrupt control byte. Transfers are a short conversation: the host writes a command byte, then one or two bytes on the data port, and paces every step by polling two status flags. The input-buffer-full flag says a byte is still being digested. The output-buffer-full flag says a result byte is waiting to be read.

Register accesses leave the block through a request channel with valid/ready flow control and come back on a response channel. The register file sits outside the block. A request is raised with `reg_req_valid` and must be held, with address, direction and write data unchanged, until `reg_req_ready` is sampled high. A read request is answered by a one-cycle `reg_rsp_valid` pulse carrying `reg_rsp_rdata`, at least one cycle after acceptance. The block takes that response in any cycle and applies no back-pressure to it. A response that arrives while no read is outstanding is ignored. Burst enable/disable and query commands are decoded and reported on plain flag outputs.

Top module: `ec_host_port`

## Requirements
- R1: After reset the status byte, output buffer, interrupt control byte, burst flag and query pulse are all zero, and no register request is raised.
- R2: A host write to offset 0x0 (data) or 0x4 (command) sets status bit 1 (input buffer full) for exactly LATENCY cycles when the byte needs no register access. Status bit 3 becomes 1 if the byte went to offset 0x4 and 0 if it went to offset 0x0.
- R3: A host write to offset 0x0 or 0x4 while status bit 1 is set is dropped. The held byte, its bit 3 and the sequence state are unchanged.
- R4: Command 0x80 followed by an address byte raises one read request for that address. When the response arrives, its byte is loaded into the output buffer, status bit 0 (output buffer full) is set and status bit 1 is cleared, all in the same cycle.
- R5: Command 0x81, then an address byte, then a data byte raise one write request. Status bit 1 clears in the cycle the request is accepted.
- R6: While `reg_req_valid` is high and `reg_req_ready` is low, the request and its address, direction and write data stay stable.
- R7: A host read of offset 0x0 returns the output buffer and clears status bit 0. Reading offset 0x4 leaves every flag unchanged.
- R8: A command byte written in the middle of a read or write sequence abandons that sequence, and no request is raised for it.
- R9: Command 0x82 sets status bit 4 and `burst_mode` and loads the acknowledge byte BURST_ACK with status bit 0 set. Command 0x83 clears status bit 4 and `burst_mode` and leaves the output buffer flag alone.
- R10: Command 0x84 loads 0x00 into the output buffer with status bit 0 set and pulses `query_pulse` for one cycle.
- R11: An unknown command byte, or a data byte with no sequence open, raises no request and does not touch the output buffer.
- R12: Offset 0x8 is a read/write interrupt control byte driven on `irq_ctrl`, and writing it does not set status bit 1. Reads of any other offset return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | HA_W | Host byte offset (0x0 data, 0x4 status/command, 0x8 interrupt control) |
| host_rd | input | 1 | Host read strobe, one cycle per read |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte at `host_addr` (combinational) |
| irq_ctrl | output | 8 | Interrupt control byte |
| burst_mode | output | 1 | Burst mode flag |
| query_pulse | output | 1 | One-cycle pulse after a query command |
| reg_req_valid | output | 1 | Register request valid |
| reg_req_ready | input | 1 | Register file accepts the request |
| reg_req_write | output | 1 | 1 for write, 0 for read |
| reg_req_addr | output | 8 | Register address |
| reg_req_wdata | output | 8 | Register write byte |
| reg_rsp_valid | input | 1 | Read response valid, one cycle |
| reg_rsp_rdata | input | 8 | Read response byte |

## Verification
The bench goes after the edges of the handshake. A second byte written while the input flag is still set must be dropped; a design that latched it would take it as an address and corrupt the sequence. A command arriving between the address and data bytes of a write must abort the write; a design that ignored it would store data at a stale address. The bench also holds the request channel under back-pressure, where a design that changed its fields or dropped valid early would write the wrong location. It checks that status reads never clear the output flag and that the input flag lasts exactly LATENCY cycles. A design that cleared it early would let a polling host overrun the buffer.

// File: rtl/ec_hp_pkg.sv
package ec_hp_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RD_ADDR,
    SQ_WR_ADDR,
    SQ_WR_DATA,
    SQ_RD_REQ,
    SQ_RD_WAIT,
    SQ_WR_REQ
  } seq_state_e;

  localparam logic [7:0] OP_READ      = 8'h80;
  localparam logic [7:0] OP_WRITE     = 8'h81;
  localparam logic [7:0] OP_BURST_ON  = 8'h82;
  localparam logic [7:0] OP_BURST_OFF = 8'h83;
  localparam logic [7:0] OP_QUERY     = 8'h84;
endpackage

// File: rtl/ec_hp_inbuf.sv
module ec_hp_inbuf #(
  parameter int LATENCY = 4,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_is_cmd,
  input  logic [DW-1:0] wr_data,
  input  logic          release_i,
  output logic          ibf,
  output logic          is_cmd,
  output logic          byte_valid,
  output logic [DW-1:0] byte_q
);
  localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ibf    <= 1'b0;
      cnt    <= '0;
      is_cmd <= 1'b0;
      byte_q <= '0;
    end else if (wr_en && !ibf) begin
      ibf    <= 1'b1;
      cnt    <= CNT_LOAD;
      is_cmd <= wr_is_cmd;
      byte_q <= wr_data;
    end else if (release_i) begin
      ibf <= 1'b0;
    end else if (ibf && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign byte_valid = ibf && (cnt == '0);

  a_r2_write_sets_ibf: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ibf) |=> ibf);
  a_r3_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ibf && !release_i) |=> ($stable(byte_q) && $stable(is_cmd)));
endmodule

// File: rtl/ec_hp_seq.sv
module ec_hp_seq
  import ec_hp_pkg::*;
#(
  parameter logic [7:0] BURST_ACK = 8'h90
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_valid,
  input  logic       is_cmd,
  input  logic [7:0] byte_q,
  input  logic       req_ready,
  input  logic       rsp_valid,
  input  logic [7:0] rsp_data,
  output logic       release_o,
  output logic       ob_load,
  output logic [7:0] ob_data,
  output logic       burst_mode,
  output logic       query_pulse,
  output logic       req_valid,
  output logic       req_write,
  output logic [7:0] req_addr,
  output logic [7:0] req_wdata
);
  seq_state_e st;

  always_comb begin
    release_o = 1'b0;
    ob_load   = 1'b0;
    ob_data   = rsp_data;
    case (st)
      SQ_RD_REQ: release_o = 1'b0;
      SQ_RD_WAIT: begin
        release_o = rsp_valid;
        ob_load   = rsp_valid;
      end
      SQ_WR_REQ: release_o = req_ready;
      default: begin
        if (byte_valid) begin
          if (is_cmd) begin
            release_o = 1'b1;
            if (byte_q == OP_BURST_ON) begin
              ob_load = 1'b1;
              ob_data = BURST_ACK;
            end else if (byte_q == OP_QUERY) begin
              ob_load = 1'b1;
              ob_data = 8'h00;
            end
          end else begin
            release_o = (st != SQ_RD_ADDR) && (st != SQ_WR_DATA);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= SQ_IDLE;
      req_valid   <= 1'b0;
      req_write   <= 1'b0;
      req_addr    <= '0;
      req_wdata   <= '0;
      burst_mode  <= 1'b0;
      query_pulse <= 1'b0;
    end else begin
      query_pulse <= 1'b0;
      case (st)
        SQ_RD_REQ: if (req_ready) begin
          req_valid <= 1'b0;
          st        <= SQ_RD_WAIT;
        end
        SQ_RD_WAIT: if (rsp_valid) st <= SQ_IDLE;
        SQ_WR_REQ: if (req_ready) begin
          req_valid <= 1'b0;
          st        <= SQ_IDLE;
        end
        default: begin
          if (byte_valid) begin
            if (is_cmd) begin
              case (byte_q)
                OP_READ:      st <= SQ_RD_ADDR;
                OP_WRITE:     st <= SQ_WR_ADDR;
                OP_BURST_ON:  begin burst_mode <= 1'b1; st <= SQ_IDLE; end
                OP_BURST_OFF: begin burst_mode <= 1'b0; st <= SQ_IDLE; end
                OP_QUERY:     begin query_pulse <= 1'b1; st <= SQ_IDLE; end
                default:      st <= SQ_IDLE;
              endcase
            end else begin
              case (st)
                SQ_RD_ADDR: begin
                  req_valid <= 1'b1;
                  req_write <= 1'b0;
                  req_addr  <= byte_q;
                  st        <= SQ_RD_REQ;
                end
                SQ_WR_ADDR: begin
                  req_addr <= byte_q;
                  st       <= SQ_WR_DATA;
                end
                SQ_WR_DATA: begin
                  req_valid <= 1'b1;
                  req_write <= 1'b1;
                  req_wdata <= byte_q;
                  st        <= SQ_WR_REQ;
                end
                default: st <= SQ_IDLE;
              endcase
            end
          end
        end
      endcase
    end
  end

  a_r6_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata)));
  a_r10_query_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    query_pulse |=> !query_pulse);
  a_r11_idle_data_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_IDLE && byte_valid && !is_cmd) |=> !req_valid);
endmodule

// File: rtl/ec_hp_outbuf.sv
module ec_hp_outbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          host_take,
  output logic          obf,
  output logic [DW-1:0] obuf
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obf  <= 1'b0;
      obuf <= '0;
    end else if (load) begin
      obf  <= 1'b1;
      obuf <= load_data;
    end else if (host_take) begin
      obf <= 1'b0;
    end
  end

  a_r4_load_sets_obf: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (obf && obuf == $past(load_data)));
  a_r7_take_clears_obf: assert property (@(posedge clk) disable iff (!rst_n)
    (host_take && !load) |=> !obf);
endmodule

// File: rtl/ec_host_port.sv
module ec_host_port #(
  parameter int         HA_W      = 4,
  parameter int         LATENCY   = 4,
  parameter logic [7:0] BURST_ACK = 8'h90
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HA_W-1:0] host_addr,
  input  logic            host_rd,
  input  logic            host_wr,
  input  logic [7:0]      host_wdata,
  output logic [7:0]      host_rdata,
  output logic [7:0]      irq_ctrl,
  output logic            burst_mode,
  output logic            query_pulse,
  output logic            reg_req_valid,
  input  logic            reg_req_ready,
  output logic            reg_req_write,
  output logic [7:0]      reg_req_addr,
  output logic [7:0]      reg_req_wdata,
  input  logic            reg_rsp_valid,
  input  logic [7:0]      reg_rsp_rdata
);
  localparam int DW = 8;
  localparam logic [HA_W-1:0] OFS_DATA = HA_W'(4'h0);
  localparam logic [HA_W-1:0] OFS_CTRL = HA_W'(4'h4);
  localparam logic [HA_W-1:0] OFS_ICR  = HA_W'(4'h8);

  logic hit_data, hit_ctrl, hit_icr, port_wr;
  logic ibf, is_cmd, byte_valid, release_w;
  logic [DW-1:0] byte_q;
  logic ob_load, obf;
  logic [DW-1:0] ob_data, obuf;
  logic [DW-1:0] status;

  assign hit_data = (host_addr == OFS_DATA);
  assign hit_ctrl = (host_addr == OFS_CTRL);
  assign hit_icr  = (host_addr == OFS_ICR);
  assign port_wr  = host_wr && (hit_data || hit_ctrl);

  ec_hp_inbuf #(.LATENCY(LATENCY), .DW(DW)) u_inbuf (
    .clk(clk), .rst_n(rst_n), .wr_en(port_wr), .wr_is_cmd(hit_ctrl),
    .wr_data(host_wdata), .release_i(release_w), .ibf(ibf), .is_cmd(is_cmd),
    .byte_valid(byte_valid), .byte_q(byte_q)
  );

  ec_hp_seq #(.BURST_ACK(BURST_ACK)) u_seq (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .is_cmd(is_cmd),
    .byte_q(byte_q), .req_ready(reg_req_ready), .rsp_valid(reg_rsp_valid),
    .rsp_data(reg_rsp_rdata), .release_o(release_w), .ob_load(ob_load),
    .ob_data(ob_data), .burst_mode(burst_mode), .query_pulse(query_pulse),
    .req_valid(reg_req_valid), .req_write(reg_req_write),
    .req_addr(reg_req_addr), .req_wdata(reg_req_wdata)
  );

  ec_hp_outbuf #(.DW(DW)) u_outbuf (
    .clk(clk), .rst_n(rst_n), .load(ob_load), .load_data(ob_data),
    .host_take(host_rd && hit_data), .obf(obf), .obuf(obuf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                irq_ctrl <= '0;
    else if (host_wr && hit_icr) irq_ctrl <= host_wdata;
  end

  assign status = {3'b000, burst_mode, is_cmd, 1'b0, ibf, obf};

  always_comb begin
    if (hit_data)      host_rdata = obuf;
    else if (hit_ctrl) host_rdata = status;
    else if (hit_icr)  host_rdata = irq_ctrl;
    else               host_rdata = '0;
  end

  a_r12_icr_no_ibf: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && hit_icr && !ibf) |=> !ibf);
  a_r7_status_read_keeps_obf: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && hit_ctrl && obf) |=> obf);
  a_r9_burst_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && is_cmd && byte_q == 8'h82 && !reg_req_valid) |=> burst_mode);
endmodule

// File: tb/tb_ec_host_port.sv
module tb_ec_host_port;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 4;
  localparam logic [7:0] ACK = 8'h90;
  localparam int RSP_DLY    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] host_addr = 4'h4;
  logic host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata, irq_ctrl;
  logic burst_mode, query_pulse;
  logic reg_req_valid, reg_req_write;
  logic reg_req_ready = 1'b1;
  logic [7:0] reg_req_addr, reg_req_wdata;
  logic reg_rsp_valid = 1'b0;
  logic [7:0] reg_rsp_rdata = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  ec_host_port #(.HA_W(4), .LATENCY(LAT), .BURST_ACK(ACK)) dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq_ctrl(irq_ctrl), .burst_mode(burst_mode), .query_pulse(query_pulse),
    .reg_req_valid(reg_req_valid), .reg_req_ready(reg_req_ready),
    .reg_req_write(reg_req_write), .reg_req_addr(reg_req_addr),
    .reg_req_wdata(reg_req_wdata), .reg_rsp_valid(reg_rsp_valid),
    .reg_rsp_rdata(reg_rsp_rdata)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // register file behaviour
  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  bit stall = 1'b0;
  bit rsp_wait = 1'b0;
  int rsp_cnt = 0, cyc_n = 0, req_count = 0, q_count = 0;
  logic [7:0] rsp_addr = 8'h00;

  always @(negedge clk) begin
    cyc_n++;
    reg_rsp_valid = 1'b0;
    if (rsp_wait) begin
      if (rsp_cnt == 0) begin
        reg_rsp_valid = 1'b1;
        reg_rsp_rdata = mem[rsp_addr];
        rsp_wait = 1'b0;
      end else rsp_cnt--;
    end
    reg_req_ready = stall ? (cyc_n % 3 == 0) : 1'b1;
    if (rst_n && reg_req_valid && reg_req_ready) begin
      req_count++;
      if (reg_req_write) mem[reg_req_addr] = reg_req_wdata;
      else begin
        rsp_wait = 1'b1;
        rsp_cnt  = RSP_DLY;
        rsp_addr = reg_req_addr;
      end
    end
  end

  always @(posedge clk) if (rst_n && query_pulse) q_count++;

  // behavioural reference: phase 0 idle, 1 await read addr, 2 await write addr,
  // 3 await write data, 4 read offered, 5 read in flight, 6 write offered
  int m_ph = 0, m_left = 0;
  bit m_ibf = 0, m_obf = 0, m_cmd = 0, m_burst = 0, m_q = 0, m_rv = 0, m_rw = 0;
  logic [7:0] m_byte = 0, m_obuf = 0, m_icr = 0, m_ra = 0, m_rd = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_ibf = 0; m_obf = 0; m_cmd = 0; m_burst = 0;
      m_q = 0; m_rv = 0; m_rw = 0; m_byte = 0; m_obuf = 0; m_icr = 0;
      m_ra = 0; m_rd = 0;
    end else begin
      bit rel, ld, nq;
      logic [7:0] ldv;
      rel = 0; ld = 0; nq = 0; ldv = 0;
      if (m_ph == 4) begin
        if (reg_req_ready) begin m_rv = 0; m_ph = 5; end
      end else if (m_ph == 5) begin
        if (reg_rsp_valid) begin ld = 1; ldv = reg_rsp_rdata; rel = 1; m_ph = 0; end
      end else if (m_ph == 6) begin
        if (reg_req_ready) begin m_rv = 0; rel = 1; m_ph = 0; end
      end else if (m_ibf && m_left == 0) begin
        if (m_cmd) begin
          rel = 1; m_ph = 0;
          if (m_byte == 8'h80) m_ph = 1;
          else if (m_byte == 8'h81) m_ph = 2;
          else if (m_byte == 8'h82) begin m_burst = 1; ld = 1; ldv = ACK; end
          else if (m_byte == 8'h83) m_burst = 0;
          else if (m_byte == 8'h84) begin ld = 1; ldv = 8'h00; nq = 1; end
        end else if (m_ph == 1) begin m_rv = 1; m_rw = 0; m_ra = m_byte; m_ph = 4; end
        else if (m_ph == 2) begin m_ra = m_byte; m_ph = 3; rel = 1; end
        else if (m_ph == 3) begin m_rv = 1; m_rw = 1; m_rd = m_byte; m_ph = 6; end
        else rel = 1;
      end
      if (ld) begin m_obf = 1; m_obuf = ldv; end
      else if (host_rd && host_addr == 4'h0) m_obf = 0;
      if (host_wr && (host_addr == 4'h0 || host_addr == 4'h4) && !m_ibf) begin
        m_ibf = 1; m_left = LAT - 1; m_cmd = (host_addr == 4'h4); m_byte = host_wdata;
      end else if (rel) m_ibf = 0;
      else if (m_ibf && m_left > 0) m_left--;
      if (host_wr && host_addr == 4'h8) m_icr = host_wdata;
      m_q = nq;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [7:0] exp_rd;
      case (host_addr)
        4'h0: exp_rd = m_obuf;
        4'h4: exp_rd = {3'b000, m_burst, m_cmd, 1'b0, m_ibf, m_obf};
        4'h8: exp_rd = m_icr;
        default: exp_rd = 8'h00;
      endcase
      check("R2,R7 host_rdata vs model", host_rdata, exp_rd);
      check("R9 burst_mode vs model", burst_mode, m_burst);
      check("R10 query_pulse vs model", query_pulse, m_q);
      check("R12 irq_ctrl vs model", irq_ctrl, m_icr);
      check("R6 reg_req_valid vs model", reg_req_valid, m_rv);
      if (m_rv) begin
        check("R6 reg_req_write vs model", reg_req_write, m_rw);
        check("R6 reg_req_addr vs model", reg_req_addr, m_ra);
        if (m_rw) check("R5 reg_req_wdata vs model", reg_req_wdata, m_rd);
      end
    end
  end

  task automatic hwrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0; host_addr = 4'h4;
  endtask

  task automatic hread(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1'b1; #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0; host_addr = 4'h4;
  endtask

  task automatic wait_ibf_clear();
    logic [7:0] s;
    for (int i = 0; i < 1000; i++) begin
      hread(4'h4, s);
      if (!s[1]) return;
    end
  endtask

  task automatic wait_obf_set();
    logic [7:0] s;
    for (int i = 0; i < 1000; i++) begin
      hread(4'h4, s);
      if (s[0]) return;
    end
  endtask

  task automatic ec_cmd(input logic [7:0] c);
    wait_ibf_clear(); hwrite(4'h4, c);
  endtask
  task automatic ec_data(input logic [7:0] d);
    wait_ibf_clear(); hwrite(4'h0, d);
  endtask
  task automatic ec_rd(input logic [7:0] a, output logic [7:0] d);
    ec_cmd(8'h80); ec_data(a); wait_obf_set(); hread(4'h0, d);
  endtask
  task automatic ec_wr(input logic [7:0] a, input logic [7:0] d);
    ec_cmd(8'h81); ec_data(a); ec_data(d); wait_ibf_clear();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired: actual=hung expected=complete");
    finish_run();
  end

  initial begin
    logic [7:0] v, s;
    int n, rc, qc;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      shadow[i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check("R1 status after reset", host_rdata, 8'h00);
    check("R1 no request after reset", reg_req_valid, 0);
    check("R1 burst after reset", burst_mode, 0);
    check("R1 irq_ctrl after reset", irq_ctrl, 8'h00);
    hread(4'h0, v);
    check("R1 output buffer after reset", v, 8'h00);

    // R2 latency of the input flag, unknown command (R11)
    rc = req_count;
    hwrite(4'h4, 8'h55);
    n = 0;
    #1;
    while (host_rdata[1] && n < 100) begin n++; @(negedge clk); #1; end
    check("R2 ibf high cycles", n, LAT);
    check("R2 command flag bit3", host_rdata[3], 1);
    check("R11 unknown command leaves obf", host_rdata[0], 0);
    check("R11 unknown command no request", req_count, rc);

    // R11 data byte with no sequence
    ec_data(8'h99);
    wait_ibf_clear();
    hread(4'h4, s);
    check("R2 data flag bit3 clear", s[3], 0);
    check("R11 idle data leaves obf", s[0], 0);
    check("R11 idle data no request", req_count, rc);

    // R5, R6 write under back-pressure, R4 read back
    stall = 1'b1;
    ec_wr(8'h10, 8'hA5); shadow[8'h10] = 8'hA5;
    ec_rd(8'h10, v);
    stall = 1'b0;
    check("R5 write then R4 read back", v, 8'hA5);
    ec_rd(8'h33, v);
    check("R4 read untouched register", v, shadow[8'h33]);

    // R7 status read does not clear, data read does
    ec_cmd(8'h80); ec_data(8'h44); wait_obf_set();
    hread(4'h4, s); hread(4'h4, s);
    check("R7 obf kept across status reads", s[0], 1);
    hread(4'h0, v);
    check("R7 data read value", v, shadow[8'h44]);
    hread(4'h4, s);
    check("R7 obf cleared by data read", s[0], 0);

    // R9 burst on/off
    ec_cmd(8'h82); wait_obf_set();
    check("R9 burst_mode set", burst_mode, 1);
    hread(4'h4, s);
    check("R9 status bit4 set", s[4], 1);
    hread(4'h0, v);
    check("R9 acknowledge byte", v, ACK);
    ec_cmd(8'h83); wait_ibf_clear();
    hread(4'h4, s);
    check("R9 status bit4 cleared", s[4], 0);
    check("R9 burst off leaves obf clear", s[0], 0);
    check("R9 burst_mode cleared", burst_mode, 0);

    // R10 query
    qc = q_count;
    ec_cmd(8'h84); wait_obf_set();
    hread(4'h0, v);
    check("R10 query returns zero", v, 8'h00);
    check("R10 one query pulse", q_count, qc + 1);

    // R8 abort mid write
    rc = req_count;
    ec_cmd(8'h81); ec_data(8'h20); ec_cmd(8'h80); ec_data(8'h20);
    wait_obf_set(); hread(4'h0, v);
    check("R8 aborted write left register", v, shadow[8'h20]);
    check("R8 only the read was requested", req_count, rc + 1);

    // R3 write while input flag is busy
    ec_cmd(8'h81);
    hwrite(4'h0, 8'h33);
    #1;
    check("R3 held byte still a command", host_rdata[3], 1);
    ec_data(8'h30); ec_data(8'h77); wait_ibf_clear(); shadow[8'h30] = 8'h77;
    ec_rd(8'h30, v);
    check("R3 dropped byte did not shift sequence", v, 8'h77);
    ec_rd(8'h33, v);
    check("R3 dropped byte not used as address", v, shadow[8'h33]);

    // R12 interrupt control byte and unmapped offsets
    hwrite(4'h8, 8'h3C);
    #1;
    check("R12 irq_ctrl output", irq_ctrl, 8'h3C);
    check("R12 icr write leaves ibf clear", host_rdata[1], 0);
    hread(4'h8, v);
    check("R12 icr read back", v, 8'h3C);
    hread(4'hC, v);
    check("R12 unmapped offset reads zero", v, 8'h00);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule